// File: doc/BRIEF.md
# Peripheral Access Spacing Guard

This block sits between a chip-select decoder and a slow peripheral that needs recovery time between bus accesses. It holds the processor's ready line low, adding wait states, whenever the next access would come too soon. While ready is low, the strobe to the peripheral is withheld. The access goes out in the first cycle in which every spacing rule is met.

Two rules are enforced independently. The first applies to every read and write. After a strobe ends, a fixed number of system clocks must pass before the next strobe. That count is derived from a recovery time and a clock period, both given in picoseconds. The second rule applies only to writes to one command-register address. Between two such writes, a set number of rising edges of the peripheral's own free-running oscillator must be seen. Those edges pass through a two-flop synchroniser and an edge detector before they are counted.

Each access lasts one bus cycle, and the processor holds select, direction and address steady while it waits. The strobe is one cycle long and the recovery gap is at least one cycle. A dummy select followed at once by a real one therefore reaches the peripheral as two separate strobes and never as one long strobe with a changing address.

Top module: `access_spacing_guard`

## Requirements
- R1: After reset, with no select, `rdy_o` is 1 and `cs_o` and `we_o` are 0. The first access after reset is granted at once, including a command-register write.
- R2: A granted cycle is a cycle with `sel_i`=1 in which both rules are met. In that cycle `cs_o`=1, `rdy_o`=1 and `we_o` equals `wr_i` (1 = write, 0 = read).
- R3: With `sel_i`=0, `rdy_o` is 1 and `cs_o` is 0.
- R4: After any granted read or write, the next GAP cycles cannot be granted. If `sel_i` is held, `rdy_o` is 0 in those cycles. The cycle after them can be granted.
- R5: GAP = ceil(`REC_PS` / `CLK_PS`), with a minimum of 1. For example, 45000 / 10000 gives 5.
- R6: A write to address `CMD_ADDR` is not granted until `CMD_EDGES` synchronised rising edges of `pclk_i` have been detected since the previous granted command-register write. Edges that arrive during the recovery gap count.
- R7: Reads of `CMD_ADDR` and writes to other addresses are not subject to the edge rule, and they do not restart the edge count.
- R8: While `rdy_o` is 0, `cs_o` and `we_o` stay 0.
- R9: `cs_o` is never 1 in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; clears all state to the satisfied condition |
| sel_i | input | 1 | Decoded select for the peripheral in this bus cycle |
| wr_i | input | 1 | Access direction: 1 = write, 0 = read |
| addr_i | input | ADDR_W | Register address within the peripheral |
| pclk_i | input | 1 | Peripheral oscillator clock, asynchronous to clk |
| rdy_o | output | 1 | Ready to the processor; 0 inserts a wait state |
| cs_o | output | 1 | One-cycle chip-enable strobe to the peripheral |
| we_o | output | 1 | Write qualifier, valid while cs_o is 1 |

## Verification
A gap counter that restarts late or saturates early shows up at the ports in the first access after a strobe. That access is then granted a cycle early or late, which shows as `rdy_o` and `cs_o` taking the wrong value in a single sampled cycle. A fault in the edge counter or the synchroniser shows up when a command-register write is held back after the required number of peripheral-clock edges, or is let through with one edge too few. Stray restarts on reads or on writes to other addresses show up as a later command write being held when it should pass.

// File: rtl/access_spacing_guard_pkg.sv
`timescale 1ns/1ps
package access_spacing_guard_pkg;

  // Recovery window in system clocks: ceil(rec / clk), never below one.
  function automatic int unsigned gap_cycles(int unsigned rec_ps, int unsigned clk_ps);
    int unsigned q;
    q = (rec_ps + clk_ps - 1) / clk_ps;
    if (q == 0) q = 1;
    return q;
  endfunction

  // Bits needed to hold values 0..maxv.
  function automatic int unsigned count_bits(int unsigned maxv);
    int unsigned b;
    b = $clog2(maxv + 1);
    if (b == 0) b = 1;
    return b;
  endfunction

endpackage

// File: rtl/spacing_sat_counter.sv
`timescale 1ns/1ps
// Counts up to LIMIT and holds there; restart clears it.
module spacing_sat_counter #(
  parameter int unsigned LIMIT = 3,
  parameter int unsigned CW    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic step_i,
  output logic done_o
);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= TOP;
    else if (restart_i)         cnt_q <= '0;
    else if (step_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spacing_edge_sync.sv
`timescale 1ns/1ps
// Two-flop synchroniser followed by a rising-edge detector.
module spacing_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic meta_q, sync_q, last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
      last_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~last_q;
endmodule

// File: rtl/access_spacing_guard.sv
`timescale 1ns/1ps
module access_spacing_guard
  import access_spacing_guard_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned CMD_ADDR  = 1,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned REC_PS    = 150000,
  parameter int unsigned CMD_EDGES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              pclk_i,
  output logic              rdy_o,
  output logic              cs_o,
  output logic              we_o
);
  localparam int unsigned GAP    = gap_cycles(REC_PS, CLK_PS);
  localparam int unsigned GAP_W  = count_bits(GAP);
  localparam int unsigned EDGE_W = count_bits(CMD_EDGES);
  localparam logic [ADDR_W-1:0] CMD_SEL = ADDR_W'(CMD_ADDR);

  // Named internal events, also observed by the checker.
  logic cmd_wr, gap_ok, edge_ok, access_ok, grant, cmd_wr_grant, pclk_rise;

  assign cmd_wr       = sel_i & wr_i & (addr_i == CMD_SEL);
  assign access_ok    = gap_ok & (edge_ok | ~cmd_wr);
  assign grant        = sel_i & access_ok;
  assign cmd_wr_grant = grant & cmd_wr;

  assign rdy_o = ~sel_i | access_ok;
  assign cs_o  = grant;
  assign we_o  = grant & wr_i;

  // Recovery window: restarts as each strobe ends, counts system clocks.
  spacing_sat_counter #(.LIMIT(GAP), .CW(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .restart_i(grant), .step_i(1'b1), .done_o(gap_ok)
  );

  spacing_edge_sync u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pclk_i), .rise_o(pclk_rise)
  );

  // Command-register window: restarts only on a granted command write.
  spacing_sat_counter #(.LIMIT(CMD_EDGES), .CW(EDGE_W)) u_edges (
    .clk(clk), .rst_n(rst_n), .restart_i(cmd_wr_grant), .step_i(pclk_rise), .done_o(edge_ok)
  );
endmodule

// File: rtl/access_spacing_guard_chk.sv
`timescale 1ns/1ps
module access_spacing_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_i,
  input logic wr_i,
  input logic rdy_o,
  input logic cs_o,
  input logic we_o,
  input logic grant,
  input logic cmd_wr_grant,
  input logic gap_ok,
  input logic edge_ok
);
  assert_stall_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_o |-> (!cs_o && !we_o));

  assert_ce_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_o |=> !cs_o);

  assert_idle_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_i |-> (rdy_o && !cs_o));

  assert_grant_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && rdy_o) |-> (cs_o && (we_o == wr_i)));

  assert_gap_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> !gap_ok);

  assert_edge_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_grant |=> !edge_ok);
endmodule

bind access_spacing_guard access_spacing_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .wr_i(wr_i),
  .rdy_o(rdy_o), .cs_o(cs_o), .we_o(we_o),
  .grant(grant), .cmd_wr_grant(cmd_wr_grant),
  .gap_ok(gap_ok), .edge_ok(edge_ok)
);

// File: tb/access_spacing_guard_bench.sv
`timescale 1ns/1ps
module access_spacing_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0, wr = 1'b0, pclk = 1'b0;
  logic [2:0] addr = '0;
  logic rdy, cs, we;
  int vecs = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // REC_PS/CLK_PS = 4.5 -> gap of 5 cycles (R5); command register at address 1.
  access_spacing_guard #(.ADDR_W(3), .CMD_ADDR(1), .CLK_PS(10000),
                         .REC_PS(45000), .CMD_EDGES(3)) u_access_spacing_guard (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .wr_i(wr), .addr_i(addr),
    .pclk_i(pclk), .rdy_o(rdy), .cs_o(cs), .we_o(we)
  );

  // Row: sel, wr, addr[2:0], expected rdy, cs, we. pclk stays low throughout.
  localparam logic [7:0] VEC [NV] = '{
    8'b0_0_000_1_0_0,                                                   // 0  R3 idle
    8'b1_0_010_1_1_0,                                                   // 1  R1 first read granted
    8'b1_0_010_0_0_0, 8'b1_0_010_0_0_0, 8'b1_0_010_0_0_0,
    8'b1_0_010_0_0_0, 8'b1_0_010_0_0_0,                                 // 2-6 R4/R8/R9 gap
    8'b1_0_010_1_1_0,                                                   // 7  R5 granted after 5
    8'b0_0_000_1_0_0, 8'b0_0_000_1_0_0, 8'b0_0_000_1_0_0,
    8'b0_0_000_1_0_0, 8'b0_0_000_1_0_0,                                 // 8-12 R3 idle
    8'b1_1_001_1_1_1,                                                   // 13 R2 command write
    8'b1_1_100_0_0_0, 8'b1_1_100_0_0_0, 8'b1_1_100_0_0_0,
    8'b1_1_100_0_0_0, 8'b1_1_100_0_0_0,                                 // 14-18 R4 write gap
    8'b1_1_100_1_1_1,                                                   // 19 R7 other write free
    8'b1_1_001_0_0_0, 8'b1_1_001_0_0_0, 8'b1_1_001_0_0_0,
    8'b1_1_001_0_0_0, 8'b1_1_001_0_0_0,                                 // 20-24 R4 gap
    8'b1_1_001_0_0_0,                                                   // 25 R6 no edges yet
    8'b1_0_001_1_1_0                                                    // 26 R7 command read free
  };
  localparam int VTAG [NV] = '{3, 1, 9, 8, 8, 4, 4, 5, 3, 3, 3, 3, 3, 2,
                               4, 4, 4, 4, 4, 7, 4, 4, 4, 4, 4, 6, 7};

  task automatic check(input string tag, input logic e_rdy, e_cs, e_we);
    vecs++;
    if (rdy !== e_rdy || cs !== e_cs || we !== e_we) begin
      bad++;
      $display("FAIL %s rdy/cs/we=%b%b%b expected %b%b%b", tag, rdy, cs, we, e_rdy, e_cs, e_we);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic [2:0] a);
    @(negedge clk);
    sel = s; wr = w; addr = a;
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) drive(1'b0, 1'b0, 3'd0);
  endtask

  task automatic pclk_edge();
    @(negedge clk); pclk = 1'b1;
    idle(4);
    pclk = 1'b0;
    idle(4);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog R1 run did not end: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    check("R1 in reset", 1'b1, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][7], VEC[i][6], VEC[i][5:3]);
      check($sformatf("R%0d row %0d", VTAG[i], i), VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R6: two edges since the last command write are not enough.
    idle(6);
    pclk_edge(); pclk_edge();
    drive(1'b1, 1'b1, 3'd1);
    check("R6 two edges held", 1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 3'd0);
    check("R3 idle after hold", 1'b1, 1'b0, 1'b0);

    // R6: third edge releases the command write.
    pclk_edge();
    drive(1'b1, 1'b1, 3'd1);
    check("R6 third edge grants", 1'b1, 1'b1, 1'b1);

    // R7: edges during the gap count; a write elsewhere does not restart the count.
    pclk_edge(); pclk_edge(); pclk_edge();
    drive(1'b1, 1'b1, 3'd4);
    check("R7 other write granted", 1'b1, 1'b1, 1'b1);
    idle(6);
    drive(1'b1, 1'b1, 3'd1);
    check("R7 command write not restarted", 1'b1, 1'b1, 1'b1);

    // R6 again: right after a command write, with gap met but no edges.
    idle(6);
    drive(1'b1, 1'b1, 3'd1);
    check("R6 no edges held", 1'b0, 1'b0, 1'b0);

    // R1: reset clears the edge rule.
    @(negedge clk); rst_n = 1'b0; sel = 1'b0;
    idle(2);
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 1'b1, 3'd1);
    check("R1 command write after reset", 1'b1, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 3'd1);
    check("R9 strobe drops next cycle", 1'b0, 1'b0, 1'b0);
    idle(1);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule